// File: doc/BRIEF.md
# Vector Element Sign-Bit Gather and Count Unit

This unit looks at a 128-bit vector as a row of equal-width elements and takes the top bit of each element. The element width is chosen per operation: byte, halfword, word, doubleword or quadword. In gather mode, those top bits are packed into a dense mask in the low end of a 64-bit scalar result. In count mode, the unit counts how many of the gathered bits match a chosen polarity. It then places that count in the upper bits of the 64-bit result, at a position set by the element width.

The datapath has no state of its own. A single output register follows it and loads only when `in_valid` is high. `out_valid` repeats `in_valid` one cycle later. Two kinds of request are rejected: an element-size code outside the five defined values, and count mode with quadword elements. A rejected request returns a zero result with `out_illegal` set.

Top module: `sign_gather_count`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_result` and `out_illegal` to zero.
- R2: `out_valid` in each cycle equals `in_valid` sampled at the previous rising clock edge.
- R3: `out_result` and `out_illegal` load on a rising edge where `in_valid` is high. Otherwise they hold their previous values.
- R4: The size codes are 0 = byte, 1 = halfword, 2 = word, 3 = doubleword and 4 = quadword. In gather mode (`in_count` = 0), result bit i is the top bit of element i, where element 0 holds the least significant bits of `in_vec`. The mask is 16, 8, 4, 2 or 1 bits wide for these sizes, and every result bit above the mask is zero.
- R5: In gather mode with size code 4, result bit 0 equals `in_vec[127]` and result bits 63:1 are zero.
- R6: In count mode (`in_count` = 1) with `in_pol` = 1, the count is the number of gathered mask bits that equal 1.
- R7: In count mode with `in_pol` = 0, the count is the number of gathered mask bits that equal 0. Only the 16, 8, 4 or 2 bits that are valid for the size are counted.
- R8: In count mode, the count is shifted left by 56 + size code (56, 57, 58 or 59 for sizes 0 to 3). Result bits 55:0 are zero.
- R9: Size codes 5, 6 or 7, or count mode with size code 4, set `out_illegal` to 1 and force `out_result` to zero. Every other request gives `out_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; loads the output register |
| in_vec | input | 128 | Source vector |
| in_size | input | 3 | Element-size code (0 byte ... 4 quadword) |
| in_count | input | 1 | 0 = gather mask, 1 = polarity count |
| in_pol | input | 1 | Polarity counted in count mode |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_result | output | 64 | Registered mask or positioned count |
| out_illegal | output | 1 | Registered flag for an unsupported request |

## Verification
The assertions check four things on every cycle. They check the valid timing. They check that the register holds when no request arrives. They check that a flagged result is zero. They also check that nothing appears above the mask in gather mode or below bit 56 in count mode.

Those properties only look at layout. They cannot tell whether the bits in the mask come from the right elements, in the right order, or whether a count is correct for the chosen polarity. Those values are shown only by the bench scenarios, which compare every cycle against a reference model that works element by element.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
    localparam int VEC_W     = 128;
    localparam int RES_W     = 64;
    localparam int MIN_EW    = 8;
    localparam int NUM_SIZES = 5;
    localparam int MAX_BITS  = VEC_W / MIN_EW;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);
    localparam int CNT_BASE  = RES_W - 8;

    typedef enum logic [2:0] {
        ESZ_BYTE  = 3'd0,
        ESZ_HALF  = 3'd1,
        ESZ_WORD  = 3'd2,
        ESZ_DWORD = 3'd3,
        ESZ_QUAD  = 3'd4
    } esize_e;

    typedef struct packed {
        logic             illegal;
        logic [RES_W-1:0] data;
    } sgc_res_t;

    function automatic logic size_defined(input logic [2:0] s);
        return s <= 3'(ESZ_QUAD);
    endfunction
endpackage

// File: rtl/sgc_gather.sv
module sgc_gather
    import sgc_pkg::*;
(
    input  logic [VEC_W-1:0]    vec,
    input  logic [2:0]          size,
    output logic [MAX_BITS-1:0] mask,
    output logic [MAX_BITS-1:0] lanes
);
    logic [MAX_BITS-1:0] per_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int EW = MIN_EW << s;
        localparam int N  = VEC_W / EW;
        logic [MAX_BITS-1:0] bits_g;
        always_comb begin
            bits_g = '0;
            for (int e = 0; e < N; e++) begin
                bits_g[e] = vec[e*EW + EW - 1];
            end
        end
        assign per_size[s] = bits_g;
    end

    always_comb begin
        mask  = '0;
        lanes = '0;
        if (size_defined(size)) begin
            mask  = per_size[size];
            lanes = MAX_BITS'((32'd1 << (MAX_BITS >> size)) - 32'd1);
        end
    end
endmodule

// File: rtl/sgc_count.sv
module sgc_count
    import sgc_pkg::*;
(
    input  logic [MAX_BITS-1:0] mask,
    input  logic [MAX_BITS-1:0] lanes,
    input  logic                pol,
    output logic [CNT_W-1:0]    cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (lanes[i] && (mask[i] == pol)) cnt = cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sign_gather_count.sv
module sign_gather_count
    import sgc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] in_vec,
    input  logic [2:0]   in_size,
    input  logic         in_count,
    input  logic         in_pol,
    output logic         out_valid,
    output logic [63:0]  out_result,
    output logic         out_illegal
);
    logic [MAX_BITS-1:0] mask, lanes;
    logic [CNT_W-1:0]    cnt;
    sgc_res_t            nxt, held;
    logic                bad;

    sgc_gather u_gather (.vec(in_vec), .size(in_size), .mask(mask), .lanes(lanes));
    sgc_count  u_count  (.mask(mask), .lanes(lanes), .pol(in_pol), .cnt(cnt));

    always_comb begin
        bad = !size_defined(in_size) || (in_count && (in_size == 3'(ESZ_QUAD)));
        nxt.illegal = bad;
        if (bad)
            nxt.data = '0;
        else if (in_count)
            nxt.data = RES_W'(cnt) << (CNT_BASE + int'(in_size));
        else
            nxt.data = RES_W'(mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) held <= nxt;
        end
    end

    assign out_result  = held.data;
    assign out_illegal = held.illegal;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0));
    a_r4_mask_width: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_count && in_size <= 3'd4)
        |=> ((out_result >> (MAX_BITS >> $past(in_size))) == '0));
    a_r8_count_low_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_count && in_size < 3'd4) |=> (out_result[55:0] == '0));
endmodule

// File: tb/sign_gather_count_tb.sv
module sign_gather_count_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_vec;
    logic [2:0]   in_size;
    logic         in_count;
    logic         in_pol;
    logic         out_valid;
    logic [63:0]  out_result;
    logic         out_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    logic        exp_v;
    logic [63:0] exp_r;
    logic        exp_ill;

    always #10 clk = ~clk;

    sign_gather_count u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .in_size(in_size), .in_count(in_count), .in_pol(in_pol),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic [64:0] ref_model(input logic [127:0] v, input int sz,
                                              input logic cm, input logic p);
        logic [63:0] m;
        int c;
        int ew;
        int n;
        if (sz > 4 || (cm && sz == 4)) return {1'b1, 64'd0};
        ew = 8 << sz;
        n  = 128 / ew;
        m  = '0;
        c  = 0;
        for (int i = 0; i < n; i++) begin
            m[i] = v[i*ew + ew - 1];
            if (m[i] == p) c++;
        end
        if (cm) return {1'b0, 64'(c) << (56 + sz)};
        return {1'b0, m};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (out_valid !== exp_v || out_result !== exp_r || out_illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: got v=%0b r=%h ill=%0b, expected v=%0b r=%h ill=%0b",
                     tag, out_valid, out_result, out_illegal, exp_v, exp_r, exp_ill);
        end
    endtask

    task automatic step(input logic v, input logic [127:0] vec, input logic [2:0] sz,
                        input logic cm, input logic p, input string tag);
        logic [64:0] r;
        in_valid = v; in_vec = vec; in_size = sz; in_count = cm; in_pol = p;
        @(posedge clk);
        exp_v = v;
        if (v) begin
            r = ref_model(vec, int'(sz), cm, p);
            exp_ill = r[64];
            exp_r   = r[63:0];
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] pat;
        rst = 1'b1; in_valid = 1'b0; in_vec = '0; in_size = '0; in_count = 1'b0; in_pol = 1'b0;
        exp_v = 1'b0; exp_r = '0; exp_ill = 1'b0;
        repeat (2) @(negedge clk);
        compare("R1 reset state");
        rst = 1'b0;

        // R4 gather per size, distinct patterns
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 128'h8000_0000_0000_0001_8080_0000_FFFF_0080, 3'(s), 1'b0, 1'b0, "R4 gather pattern A");
            step(1'b1, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 3'(s), 1'b0, 1'b0, "R4 gather pattern B");
            step(1'b1, {128{1'b1}}, 3'(s), 1'b0, 1'b0, "R4 gather all ones");
        end
        // R5 quadword gather
        step(1'b1, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 3'd4, 1'b0, 1'b0, "R5 quad top set");
        step(1'b1, 128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 3'd4, 1'b0, 1'b0, "R5 quad top clear");

        // R6/R7/R8 counts
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 3'(s), 1'b1, 1'b1, "R6 R8 count ones");
            step(1'b1, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 3'(s), 1'b1, 1'b0, "R7 R8 count zeros");
            step(1'b1, '0, 3'(s), 1'b1, 1'b0, "R7 R8 all zero full count");
            step(1'b1, {128{1'b1}}, 3'(s), 1'b1, 1'b1, "R6 R8 all ones full count");
        end

        // R9 illegal combos
        step(1'b1, {128{1'b1}}, 3'd4, 1'b1, 1'b1, "R9 count with quad");
        for (int s = 5; s < 8; s++)
            step(1'b1, {128{1'b1}}, 3'(s), 1'b0, 1'b0, "R9 undefined size");
        step(1'b1, 128'h80, 3'd0, 1'b0, 1'b0, "R9 legal clears flag");

        // R3 hold / R2 valid drop
        step(1'b0, {128{1'b1}}, 3'd0, 1'b1, 1'b1, "R3 R2 idle holds result");
        step(1'b0, '0, 3'd7, 1'b0, 1'b0, "R3 idle illegal input ignored");
        step(1'b1, 128'h8000_0000_0000_0000_8000_0000_0000_0000, 3'd3, 1'b0, 1'b0, "R2 valid returns");

        // mixed pseudo-random traffic
        for (int k = 0; k < 200; k++) begin
            pat = {$urandom, $urandom, $urandom, $urandom};
            step(1'($urandom), pat, 3'($urandom), 1'($urandom), 1'($urandom), "R4 R6 R7 R9 mixed");
        end

        // R1 mid-run reset
        step(1'b1, {128{1'b1}}, 3'd0, 1'b0, 1'b0, "R4 before reset");
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        exp_v = 1'b0; exp_r = '0; exp_ill = 1'b0;
        @(negedge clk);
        compare("R1 reset mid run");
        rst = 1'b0;
        finish_run();
    end
endmodule